// File: doc/BRIEF.md
# Interrupt Level Dispatcher

This block sits beside a processor's exception logic. Each clock it looks at the pending interrupt level from the interrupt controller and at the current status word. It decides whether that interrupt is taken. When it is, the block commits every architectural side effect in a single registered update: banked copies of the program counter and status, the exception cause, the rewritten status word, and the address of the handler to fetch from next.

Levels above one are vectored directly. Each has its own PC and status save registers, and taking one raises the status interrupt-level field to that level. Level one is never vectored directly. It is converted into a kernel, user or double exception, depending on the exception-mode and user-mode bits of the status word. Handler addresses are either fixed offsets from a default base or, with relocation enabled, the same offsets applied to a programmable base input. When nothing is taken, the PC and status pass through with one cycle of latency and all saved state holds.

Status word layout (decoded by neighbouring logic): bits [3:0] interrupt level, bit 4 exception mode, bit 5 user mode. Handler offsets from the vector base: level L>1 at 0x180 + L*0x20, kernel at 0x300, user at 0x340, double at 0x3C0.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken only if `irq_level` is strictly greater than `ps_in[3:0]` and not greater than NLEVEL (default 6).
- R2: An interrupt is taken only if the mask slice for `irq_level` (bits `[L*NUM_INT +: NUM_INT]` of `level_mask`), ANDed with `int_set` and `int_enable`, is nonzero.
- R3: On a taken level L>1, the save-PC slot for L (`epc_out[(L-1)*XLEN +: XLEN]`) receives `pc_in`. The save-status slot for L (`eps_out[(L-2)*XLEN +: XLEN]`) receives `ps_in`.
- R4: On a taken level L>1, `ps_out` equals `ps_in` with bits [3:0] replaced by L and bit 4 set. `pc_out` is base + 0x180 + L*0x20.
- R5: On a taken level-1 interrupt, `cause_out` becomes L1_CAUSE (default 4).
- R6: On a taken level-1 interrupt with `ps_in[4]` set, `depc_out` receives `pc_in` and `pc_out` is base + 0x3C0. With HAS_DEPC = 0, the level-1 save-PC slot receives `pc_in` instead.
- R7: On a taken level-1 interrupt with `ps_in[4]` clear, the level-1 save-PC slot receives `pc_in`. `pc_out` is base + 0x340 if `ps_in[5]` is set, else base + 0x300. `ps_out` is `ps_in` with bit 4 set.
- R8: With RELOC_EN = 1 (default), the base is the `vecbase` input. Otherwise it is DEF_VECBASE.
- R9: `taken` is high for exactly the cycle in which that interrupt's outputs appear, one clock after the inputs. All of that interrupt's updates appear in that same cycle.
- R10: When the take conditions fail, `pc_out` and `ps_out` equal the previous cycle's `pc_in` and `ps_in`. The save registers and `cause_out` hold.
- R11: Reset (active-low `rst_n`) clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level | input | 4 | Pending interrupt level |
| int_set | input | NUM_INT | Raised interrupt lines |
| int_enable | input | NUM_INT | Enabled interrupt lines |
| level_mask | input | (NLEVEL+1)*NUM_INT | Per-level membership masks, level L at slice L |
| pc_in | input | XLEN | Current program counter |
| ps_in | input | XLEN | Current status word |
| vecbase | input | XLEN | Programmable vector base |
| taken | output | 1 | Interrupt accepted this cycle |
| pc_out | output | XLEN | Next PC: handler address or passed-through PC |
| ps_out | output | XLEN | Next status word |
| cause_out | output | XLEN | Exception cause register |
| epc_out | output | NLEVEL*XLEN | Save-PC registers, level L at slice L-1 |
| eps_out | output | (NLEVEL-1)*XLEN | Save-status registers, level L at slice L-2 |
| depc_out | output | XLEN | Double-exception PC register |

## Verification
Two functions can decide the same cycle: the level comparison against the status field, and the gating by the mask, set and enable product. Either one alone must veto the take. The bench provokes this in two ways. It presents a level that passes the comparison but has a disabled line. It also presents a level with live lines that is equal to the current level or above NLEVEL. Each such cycle is judged by checking that `taken` stays low, that the PC and status pass through, and that every save register keeps its earlier value. In the level-1 cycles, the cause write and the choice of vector coincide. Each of those cycles is judged on all outputs at once.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int          XLEN        = 32,
  parameter int          NUM_INT     = 32,
  parameter int          NLEVEL      = 6,
  parameter bit          RELOC_EN    = 1'b1,
  parameter bit          HAS_DEPC    = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [31:0] L1_CAUSE    = 32'd4,
  parameter logic [31:0] OFF_LVL     = 32'h180,
  parameter logic [31:0] LVL_STEP    = 32'h20,
  parameter logic [31:0] OFF_KERNEL  = 32'h300,
  parameter logic [31:0] OFF_USER    = 32'h340,
  parameter logic [31:0] OFF_DOUBLE  = 32'h3C0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [3:0]                    irq_level,
  input  logic [NUM_INT-1:0]            int_set,
  input  logic [NUM_INT-1:0]            int_enable,
  input  logic [(NLEVEL+1)*NUM_INT-1:0] level_mask,
  input  logic [XLEN-1:0]               pc_in,
  input  logic [XLEN-1:0]               ps_in,
  input  logic [XLEN-1:0]               vecbase,
  output logic                          taken,
  output logic [XLEN-1:0]               pc_out,
  output logic [XLEN-1:0]               ps_out,
  output logic [XLEN-1:0]               cause_out,
  output logic [NLEVEL*XLEN-1:0]        epc_out,
  output logic [(NLEVEL-1)*XLEN-1:0]    eps_out,
  output logic [XLEN-1:0]               depc_out
);
  localparam int EXCM = 4;
  localparam int UM   = 5;

  logic [NUM_INT-1:0] sel_mask;
  logic [XLEN-1:0]    vec_off, base, ps_take;
  logic               lvl_ok, take, hi, excm;
  logic [XLEN-1:0]    epc_q [1:NLEVEL];
  logic [XLEN-1:0]    eps_q [2:NLEVEL];

  always_comb begin
    sel_mask = '0;
    for (int l = 0; l <= NLEVEL; l++)
      if (32'(irq_level) == l) sel_mask = level_mask[l*NUM_INT +: NUM_INT];
  end

  assign lvl_ok = (irq_level > ps_in[3:0]) && (32'(irq_level) <= NLEVEL);
  assign take   = lvl_ok && |(sel_mask & int_set & int_enable);
  assign hi     = irq_level > 4'd1;
  assign excm   = ps_in[EXCM];
  assign base   = RELOC_EN ? vecbase : XLEN'(DEF_VECBASE);

  always_comb begin
    if (hi)             vec_off = XLEN'(OFF_LVL + 32'(irq_level) * LVL_STEP);
    else if (excm)      vec_off = XLEN'(OFF_DOUBLE);
    else if (ps_in[UM]) vec_off = XLEN'(OFF_USER);
    else                vec_off = XLEN'(OFF_KERNEL);
  end

  always_comb begin
    ps_take = ps_in;
    ps_take[EXCM] = 1'b1;
    if (hi) ps_take[3:0] = irq_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      pc_out    <= '0;
      ps_out    <= '0;
      cause_out <= '0;
      depc_out  <= '0;
      for (int l = 1; l <= NLEVEL; l++) epc_q[l] <= '0;
      for (int l = 2; l <= NLEVEL; l++) eps_q[l] <= '0;
    end else begin
      taken <= take;
      if (take) begin
        pc_out <= base + vec_off;
        ps_out <= ps_take;
        if (hi) begin
          for (int l = 2; l <= NLEVEL; l++)
            if (32'(irq_level) == l) begin
              epc_q[l] <= pc_in;
              eps_q[l] <= ps_in;
            end
        end else begin
          cause_out <= XLEN'(L1_CAUSE);
          if (excm && HAS_DEPC) depc_out <= pc_in;
          else                  epc_q[1] <= pc_in;
        end
      end else begin
        pc_out <= pc_in;
        ps_out <= ps_in;
      end
    end
  end

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_epc
    assign epc_out[(g-1)*XLEN +: XLEN] = epc_q[g];
  end
  for (genvar g = 2; g <= NLEVEL; g++) begin : g_eps
    assign eps_out[(g-2)*XLEN +: XLEN] = eps_q[g];
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int          XLEN     = 32,
  parameter int          NLEVEL   = 6,
  parameter logic [31:0] L1_CAUSE = 32'd4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            taken,
  input logic [3:0]      irq_level,
  input logic [XLEN-1:0] ps_in,
  input logic [XLEN-1:0] pc_in,
  input logic [XLEN-1:0] ps_out,
  input logic [XLEN-1:0] pc_out,
  input logic [XLEN-1:0] cause_out
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_LEVEL_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> $past(irq_level) > $past(ps_in[3:0]));  // R1
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> 32'($past(irq_level)) <= NLEVEL);  // R1
  AST_EXCM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> ps_out[4]);  // R7
  AST_HI_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && $past(irq_level) > 4'd1) |-> ps_out[3:0] == $past(irq_level));  // R4
  AST_L1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && $past(irq_level) == 4'd1) |-> cause_out == XLEN'(L1_CAUSE));  // R5
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !taken) |-> (pc_out == $past(pc_in) && ps_out == $past(ps_in)));  // R10
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !taken) |-> $stable(cause_out));  // R10
endmodule

bind irq_dispatch irq_dispatch_chk #(.XLEN(XLEN), .NLEVEL(NLEVEL), .L1_CAUSE(L1_CAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .taken(taken), .irq_level(irq_level), .ps_in(ps_in),
  .pc_in(pc_in), .ps_out(ps_out), .pc_out(pc_out), .cause_out(cause_out)
);

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
  localparam int NL = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]        irq_level = '0;
  logic [31:0]       int_set = '0, int_enable = '0, pc_in = '0, ps_in = '0, vecbase = '0;
  logic [(NL+1)*32-1:0] level_mask;
  logic              taken;
  logic [31:0]       pc_out, ps_out, cause_out, depc_out;
  logic [NL*32-1:0]  epc_out;
  logic [(NL-1)*32-1:0] eps_out;

  irq_dispatch u0 (.clk(clk), .rst_n(rst_n), .irq_level(irq_level), .int_set(int_set),
    .int_enable(int_enable), .level_mask(level_mask), .pc_in(pc_in), .ps_in(ps_in),
    .vecbase(vecbase), .taken(taken), .pc_out(pc_out), .ps_out(ps_out),
    .cause_out(cause_out), .epc_out(epc_out), .eps_out(eps_out), .depc_out(depc_out));

  always #2 clk = ~clk;

  typedef struct packed {
    logic tk; logic [31:0] pc, ps, cause, depc;
    logic [NL*32-1:0] epc; logic [(NL-1)*32-1:0] eps;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  logic [31:0] m_epc [1:NL];
  logic [31:0] m_eps [2:NL];
  logic [31:0] m_cause = '0, m_depc = '0;

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] lvl, logic [31:0] ps, pc, set, en, vb, string tag);
    exp_t e;
    logic [31:0] msk;
    logic tk;
    @(negedge clk); #1;
    irq_level = lvl; ps_in = ps; pc_in = pc; int_set = set; int_enable = en; vecbase = vb;
    msk = (lvl <= NL) ? (32'h1 << lvl) : 32'h0;
    tk  = (lvl > ps[3:0]) && (lvl <= NL) && |(msk & set & en);
    e.tk = tk; e.pc = pc; e.ps = ps;
    if (tk) begin
      if (lvl > 1) begin
        m_epc[lvl] = pc; m_eps[lvl] = ps;
        e.ps = {ps[31:5], 1'b1, lvl};
        e.pc = vb + 32'h180 + 32'(lvl) * 32'h20;
      end else begin
        m_cause = 32'd4;
        e.ps = ps | 32'h10;
        if (ps[4]) begin m_depc = pc; e.pc = vb + 32'h3C0; end
        else begin m_epc[1] = pc; e.pc = vb + (ps[5] ? 32'h340 : 32'h300); end
      end
    end
    e.cause = m_cause; e.depc = m_depc;
    for (int l = 1; l <= NL; l++) e.epc[(l-1)*32 +: 32] = m_epc[l];
    for (int l = 2; l <= NL; l++) e.eps[(l-2)*32 +: 32] = m_eps[l];
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, "taken", 256'(taken), 256'(e.tk));
      chk(t, "pc_out", 256'(pc_out), 256'(e.pc));
      chk(t, "ps_out", 256'(ps_out), 256'(e.ps));
      chk(t, "cause_out", 256'(cause_out), 256'(e.cause));
      chk(t, "depc_out", 256'(depc_out), 256'(e.depc));
      chk(t, "epc_out", 256'(epc_out), 256'(e.epc));
      chk(t, "eps_out", 256'(eps_out), 256'(e.eps));
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l <= NL; l++) level_mask[l*32 +: 32] = 32'h1 << l;
    for (int l = 1; l <= NL; l++) m_epc[l] = '0;
    for (int l = 2; l <= NL; l++) m_eps[l] = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset taken", 256'(taken), 256'(0));
    chk("R11", "reset pc/ps/cause/depc", {pc_out, ps_out, cause_out, depc_out}, 256'(0));
    chk("R11", "reset epc", 256'(epc_out), 256'(0));
    chk("R11", "reset eps", 256'(eps_out), 256'(0));
    @(negedge clk); rst_n = 1'b1;
    // R3 R4 R8: level 3 taken from level 0
    drive(4'd3, 32'h0000_0A00, 32'h1000_0040, 32'h08, 32'h08, 32'h2000_0000, "R3 R4 R8");
    // R9: idle cycle right after the take
    drive(4'd0, 32'h0000_0013, 32'h1000_0044, 32'h0, 32'h0, 32'h2000_0000, "R9 R10");
    // R1: equal level is rejected
    drive(4'd3, 32'h0000_0003, 32'h1000_0048, 32'h08, 32'h08, 32'h2000_0000, "R1 R10");
    // R1: level above NLEVEL with every line live is rejected
    drive(4'd7, 32'h0000_0000, 32'h1000_004C, 32'hFF, 32'hFF, 32'h2000_0000, "R1 R10");
    // R2: level passes but line disabled
    drive(4'd2, 32'h0000_0000, 32'h1000_0050, 32'h04, 32'h03, 32'h2000_0000, "R2 R10");
    // R2: enabled but wrong line raised
    drive(4'd2, 32'h0000_0000, 32'h1000_0054, 32'h02, 32'hFF, 32'h2000_0000, "R2 R10");
    // R5 R7: level 1, user mode
    drive(4'd1, 32'h0000_0020, 32'h1000_0060, 32'h02, 32'h02, 32'h2000_0000, "R5 R7 user");
    // R7: level 1, kernel mode
    drive(4'd1, 32'h0000_0000, 32'h1000_0070, 32'h02, 32'h02, 32'h2000_0000, "R7 kernel");
    // R6: level 1 during exception mode -> double
    drive(4'd1, 32'h0000_0030, 32'h1000_0080, 32'h02, 32'h02, 32'h2000_0000, "R6 double");
    // R8 R4: top level with relocated base
    drive(4'd6, 32'h0000_0005, 32'h1000_0090, 32'h40, 32'h40, 32'h6000_0000, "R8 R4 R3");
    // R9: back-to-back takes on different levels
    drive(4'd2, 32'h0000_0001, 32'h1000_00A0, 32'h04, 32'h04, 32'h6000_0000, "R9 R3");
    drive(4'd4, 32'h0000_0002, 32'h1000_00B0, 32'h10, 32'h10, 32'h6000_0000, "R9 R3");
    drive(4'd0, 32'h0000_0000, 32'h1000_00C0, 32'h0, 32'h0, 32'h6000_0000, "R9 R10");
    drive(4'd5, 32'h0000_0006, 32'h1000_00D0, 32'h20, 32'h20, 32'h6000_0000, "R1 R10");
    @(negedge clk); @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule